// File: doc/BRIEF.md
# Interrupt Request and In-Service Vector Bank

This block keeps three bit vectors with one bit per interrupt vector: pending requests, per-vector enables and vectors in service. Interrupt sources assert a raise command with a vector number and withdraw it with a lower command. The core takes the winner with an acknowledge command, which moves that vector from request to in-service in a single clock. A combinational arbiter reports whether any request is pending and which requested vector has the highest number.

Software sees each vector as a run of 32-bit words on a simple register port. The address is a byte offset and words sit 16 bytes apart. The enable words can be read and written. The request and in-service words can only be read. A trigger-mode window reads as zero and refuses writes. The command inputs are plain strobes that are taken on every clock. They have no ready signal and can never be stalled, so a source needs no back-pressure handling. Register reads are combinational, and a write completes in the cycle it is presented.

Top module: `irq_vector_bank`

## Requirements
- R1: Vector v maps to bit v[4:0] of word v[7:5] in each bank. That is the same as byte v[7:3], bit v[2:0]. Word k of the in-service bank is at byte offset 0x100+16k, of the trigger-mode window at 0x180+16k, of the request bank at 0x200+16k and of the enable bank at 0x480+16k.
- R2: A raise sets the request bit of its vector only when that vector's enable bit is 1. A raise of a disabled vector leaves the request vector unchanged.
- R3: A lower clears the request bit of its vector. When a raise and a lower name the same vector in the same cycle, the raise takes effect last.
- R4: An acknowledge sets the in-service bit and clears the request bit of its vector on the same clock edge. A raise of the same vector in the same cycle is applied after the acknowledge, so the request bit stays set only if that vector is enabled. In-service bits change only through acknowledge or reset.
- R5: `pending` is 1 exactly when at least one request bit is set.
- R6: `top_vec` is the number of the highest set request bit. It is combinational from the request vector and is 0 when no bit is set.
- R7: Reset clears the request and in-service vectors and sets every enable bit to 1.
- R8: A write to an enable word takes effect on the next clock edge. A raise in the same cycle is gated by the old enable value. The write does not set `reg_err`.
- R9: Writes to request, in-service or trigger-mode words set `reg_err` and change nothing. Trigger-mode words read as 0.
- R10: An address that is unmapped or not a multiple of 16 reads as 0. A write to such an address sets `reg_err` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_valid | input | 1 | Raise strobe |
| raise_vec | input | 8 | Vector to raise |
| lower_valid | input | 1 | Lower strobe |
| lower_vec | input | 8 | Vector to lower |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vec | input | 8 | Vector to move to in-service |
| pending | output | 1 | Any request bit set |
| top_vec | output | 8 | Highest-numbered requested vector |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| reg_err | output | 1 | Current write is rejected |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions. These are a raise meeting an acknowledge, a raise meeting a lower, and a raise meeting an enable write, all on one vector. The stimulus tasks drive several command ports and the register port in the same low-clock slot, so each collision lands on a single edge. The results are then read back through the request and in-service words. Nothing clears an in-service bit except reset, so the bench resets between sweeps to get back to a known empty bank.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  // word indices (byte offset >> 4) of each bank's first word
  localparam int ISR_IDX  = 'h10;
  localparam int TRIG_IDX = 'h18;
  localparam int REQ_IDX  = 'h20;
  localparam int EN_IDX   = 'h48;
  localparam int WORD_W   = 32;
endpackage

// File: rtl/irqb_onehot.sv
module irqb_onehot #(
  parameter int N = 256,
  parameter int W = $clog2(N)
) (
  input  logic         valid,
  input  logic [W-1:0] vec,
  output logic [N-1:0] bits
);
  always_comb begin
    bits = '0;
    if (valid) bits[vec] = 1'b1;
  end
endmodule

// File: rtl/irqb_prio.sv
module irqb_prio #(
  parameter int N = 256,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] bits,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (bits[i]) idx = W'(i);
  end
  assign any = |bits;
endmodule

// File: rtl/irqb_regport.sv
module irqb_regport
  import irqb_pkg::*;
#(
  parameter int N      = 256,
  parameter int ADDR_W = 12,
  localparam int NW    = N / WORD_W,
  localparam int IW    = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [N-1:0]      req,
  input  logic [N-1:0]      isr,
  input  logic [N-1:0]      en,
  output logic [WORD_W-1:0] rdata,
  output logic [NW-1:0]     en_word_we,
  output logic              err
);
  logic [IW-1:0] idx;
  logic          aligned;
  assign idx     = addr[ADDR_W-1:4];
  assign aligned = (addr[3:0] == 4'h0);

  always_comb begin
    rdata      = '0;
    en_word_we = '0;
    if (aligned) begin
      for (int k = 0; k < NW; k++) begin
        if (idx == IW'(ISR_IDX + k)) rdata = isr[k*WORD_W +: WORD_W];
        if (idx == IW'(REQ_IDX + k)) rdata = req[k*WORD_W +: WORD_W];
        if (idx == IW'(EN_IDX + k)) begin
          rdata         = en[k*WORD_W +: WORD_W];
          en_word_we[k] = we;
        end
      end
    end
  end

  assign err = we && !(|en_word_we);
endmodule

// File: rtl/irq_vector_bank.sv
module irq_vector_bank
  import irqb_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int ADDR_W  = 12,
  localparam int VEC_W  = $clog2(NUM_VEC),
  localparam int NW     = NUM_VEC / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_valid,
  input  logic [VEC_W-1:0]  raise_vec,
  input  logic              lower_valid,
  input  logic [VEC_W-1:0]  lower_vec,
  input  logic              ack_valid,
  input  logic [VEC_W-1:0]  ack_vec,
  output logic              pending,
  output logic [VEC_W-1:0]  top_vec,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err
);
  logic [NUM_VEC-1:0] req_q, isr_q, ie_q;
  logic [NUM_VEC-1:0] raise_oh, lower_oh, ack_oh;
  logic [NW-1:0]      en_word_we;

  irqb_onehot #(.N(NUM_VEC), .W(VEC_W)) u_raise (.valid(raise_valid), .vec(raise_vec), .bits(raise_oh));
  irqb_onehot #(.N(NUM_VEC), .W(VEC_W)) u_lower (.valid(lower_valid), .vec(lower_vec), .bits(lower_oh));
  irqb_onehot #(.N(NUM_VEC), .W(VEC_W)) u_ack   (.valid(ack_valid),   .vec(ack_vec),   .bits(ack_oh));

  // lower and acknowledge clear first, a gated raise is applied last
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      isr_q <= '0;
    end else begin
      req_q <= (req_q & ~lower_oh & ~ack_oh) | (raise_oh & ie_q);
      isr_q <= isr_q | ack_oh;
    end
  end

  for (genvar k = 0; k < NW; k++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ie_q[k*WORD_W +: WORD_W] <= '1;
      else if (en_word_we[k]) ie_q[k*WORD_W +: WORD_W] <= reg_wdata;
    end
  end

  irqb_prio #(.N(NUM_VEC), .W(VEC_W)) u_prio (.bits(req_q), .any(pending), .idx(top_vec));

  irqb_regport #(.N(NUM_VEC), .ADDR_W(ADDR_W)) u_regs (
    .addr(reg_addr), .we(reg_we), .req(req_q), .isr(isr_q), .en(ie_q),
    .rdata(reg_rdata), .en_word_we(en_word_we), .err(reg_err)
  );

  // R2
  masked_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_valid && !ie_q[raise_vec]) |=> (req_q[$past(raise_vec)] == 1'b0) || $past(req_q[raise_vec] && !(lower_valid && lower_vec == raise_vec) && !(ack_valid && ack_vec == raise_vec)));
  // R3
  lower_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lower_valid && !(raise_valid && raise_vec == lower_vec)) |=> !req_q[$past(lower_vec)]);
  // R4
  ack_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !(raise_valid && raise_vec == ack_vec)) |=> isr_q[$past(ack_vec)] && !req_q[$past(ack_vec)]);
  // R4
  isr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> $stable(isr_q));
  // R6
  top_is_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> req_q[top_vec]);
  // R6
  idle_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> (top_vec == '0));
  // R9
  readonly_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_err) |=> $stable(ie_q));
endmodule

// File: tb/sim_irq_vector_bank.sv
module sim_irq_vector_bank;
  localparam int N = 256;
  logic clk = 1'b0, rst_n = 1'b0;
  logic raise_valid = 0, lower_valid = 0, ack_valid = 0, reg_we = 0;
  logic [7:0] raise_vec = 0, lower_vec = 0, ack_vec = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic pending, reg_err;
  logic [7:0] top_vec;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [N-1:0] m_req, m_isr, m_en;

  always #10 clk = ~clk;

  irq_vector_bank u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_top();
    logic [7:0] t = 0;
    for (int i = 0; i < N; i++) if (m_req[i]) t = 8'(i);
    return t;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_req = '0; m_isr = '0; m_en = '1;
  endtask

  task automatic cmd(input bit rv, input int r, input bit lv, input int l, input bit av, input int a);
    logic [N-1:0] rs, ls, as_;
    @(negedge clk);
    raise_valid = rv; raise_vec = 8'(r);
    lower_valid = lv; lower_vec = 8'(l);
    ack_valid = av;   ack_vec = 8'(a);
    rs = rv ? (N'(1) << r) : '0;
    ls = lv ? (N'(1) << l) : '0;
    as_ = av ? (N'(1) << a) : '0;
    m_req = (m_req & ~ls & ~as_) | (rs & m_en);
    m_isr = m_isr | as_;
    @(negedge clk);
    raise_valid = 0; lower_valid = 0; ack_valid = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag, input bit exp_err);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1; #1;
    chk(tag, 32'(reg_err), 32'(exp_err));
    if (!exp_err) m_en[(a - 12'h480) / 16 * 32 +: 32] = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic check_banks(input string tag);
    logic [31:0] d;
    for (int k = 0; k < 8; k++) begin
      rd(12'(32'h200 + 16*k), d); chk({tag, " R1 req"}, d, m_req[k*32 +: 32]);
      rd(12'(32'h100 + 16*k), d); chk({tag, " R1 isr"}, d, m_isr[k*32 +: 32]);
      rd(12'(32'h480 + 16*k), d); chk({tag, " R8 en"}, d, m_en[k*32 +: 32]);
    end
  endtask

  task automatic check_out(input string tag);
    chk({tag, " R5"}, 32'(pending), 32'(|m_req));
    chk({tag, " R6"}, 32'(top_vec), 32'(m_top()));
  endtask

  initial begin
    logic [31:0] d;
    do_reset();
    // R7 reset state
    check_banks("R7");
    check_out("R7");

    // R2 R6 ascending raise sweep
    for (int v = 0; v < N; v++) begin
      cmd(1, v, 0, 0, 0, 0);
      check_out("R6 raise");
    end
    check_banks("R1 all");
    // R3 descending lower sweep
    for (int v = N - 1; v >= 0; v--) begin
      cmd(0, 0, 1, v, 0, 0);
      check_out("R3 lower");
    end

    // R2 R8 enable gating with per-word patterns
    for (int k = 0; k < 8; k++) wr(12'(32'h480 + 16*k), 32'hA5C3_0F96 ^ (32'h1111_1111 * k), "R8 en wr", 0);
    for (int v = 0; v < N; v++) cmd(1, v, 0, 0, 0, 0);
    check_banks("R2 gated");
    check_out("R2 gated");
    for (int v = 0; v < N; v++) cmd(0, 0, 1, v, 0, 0);
    check_out("R3 cleared");

    // R4 acknowledge sweep with all enabled
    for (int k = 0; k < 8; k++) wr(12'(32'h480 + 16*k), 32'hFFFF_FFFF, "R8 en wr", 0);
    for (int v = 0; v < N; v += 3) cmd(1, v, 0, 0, 0, 0);
    for (int v = N - 1; v >= 0; v -= 3) begin
      cmd(0, 0, 0, 0, 1, v);
      check_out("R4 ack");
    end
    check_banks("R4 ack");

    // R4 raise+ack collision, enabled and disabled
    do_reset();
    cmd(1, 77, 0, 0, 0, 0);
    cmd(1, 77, 0, 0, 1, 77);
    check_banks("R4 collide en");
    wr(12'h490, 32'h0, "R8 en wr", 0);
    cmd(1, 40, 0, 0, 0, 0);
    cmd(1, 40, 0, 0, 1, 40);
    check_banks("R4 collide dis");
    // R3 raise+lower collision
    cmd(1, 200, 1, 200, 0, 0);
    check_banks("R3 collide");
    check_out("R3 collide");

    // R8 enable write in same cycle as raise: old enable gates
    @(negedge clk);
    reg_addr = 12'h480; reg_wdata = 32'h0; reg_we = 1;
    raise_valid = 1; raise_vec = 8'd5;
    @(negedge clk);
    reg_we = 0; raise_valid = 0;
    m_req[5] = 1'b1; m_en[31:0] = 32'h0;
    check_banks("R8 same cycle");
    cmd(1, 6, 0, 0, 0, 0);
    check_banks("R8 new en");

    // R9 read-only and trigger window
    wr(12'h200, 32'h0, "R9 req wr", 1);
    wr(12'h170, 32'hFFFF_FFFF, "R9 isr wr", 1);
    wr(12'h1A0, 32'hFFFF_FFFF, "R9 trig wr", 1);
    rd(12'h1B0, d); chk("R9 trig rd", d, 32'h0);
    check_banks("R9 unchanged");
    // R10 unmapped and misaligned
    rd(12'h484, d); chk("R10 misaligned rd", d, 32'h0);
    rd(12'h004, d); chk("R10 unmapped rd", d, 32'h0);
    rd(12'h500, d); chk("R10 past end rd", d, 32'h0);
    wr(12'h488, 32'h1234_5678, "R10 misaligned wr", 1);
    wr(12'h300, 32'h1234_5678, "R10 unmapped wr", 1);
    check_banks("R10 unchanged");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule